// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends asynchronous serial frames from a parallel holding register through a separate shift register. The host loads a word into the holding register with a one-cycle write strobe. When the transmitter is enabled and the shifter is free, the word moves into the shifter and the holding register becomes free for the next word. This lets a following word wait while the current one is still on the line. Consecutive frames then leave back to back, with no idle bit between them.

A divisor input sets the rate of an internal tick, and every bit on the line lasts sixteen ticks. A frame is a low start bit, then 8 or 9 data bits sent least significant first, then a high stop bit. As an option, the last data bit is replaced by an even or odd parity bit. The line can be driven push-pull, or open-drain for a shared wired-OR line. Dropping the enable stops new frames from starting, but a frame already on the line always finishes.

The controller has four states: IDLE (nothing on the line), START (start bit), DATA (data and parity bits) and STOP (stop bit). Its transitions are:
- IDLE→START when the enable is high and a word is waiting.
- START→DATA at the end of the start bit.
- DATA→STOP at the end of the last data bit.
- STOP→START at the end of the stop bit if the enable is high and a word is waiting.
- STOP→IDLE at the end of the stop bit otherwise.

Top module: `dbtx_uart`

## Requirements
- R1: After reset, `tdre` is 1, `tc` is 1 and the controller is in IDLE. In push-pull mode `txd_o` is 1.
- R2: The internal tick fires once every `divisor` clocks, and a divisor of 0 counts as 1. Each bit on the line lasts 16 ticks, so the first bit of a frame is held for between 15·divisor+1 and 16·divisor clocks.
- R3: A frame is sent as a 0 start bit, then K data bits with bit 0 first, then a 1 stop bit. K is 9 when `nine_bit`=1 and 8 when `nine_bit`=0. The format inputs are sampled when the frame starts.
- R4: When `par_en`=1, data bit K-1 is not sent. In its place goes the XOR of data bits 0..K-2 when `par_odd`=0, or the inverse of that XOR when `par_odd`=1.
- R5: A word written while a frame is on the line is held. Its start bit follows the stop bit of the current frame in the very next cycle.
- R6: `tdre` goes to 1 in the cycle the holding word moves into the shifter. It goes to 0 one cycle after a write strobe, and a write wins over a move in the same cycle. A second write before the move replaces the held word.
- R7: `tc` goes to 1 when a stop bit ends and no word is waiting. It goes to 0 when a frame starts.
- R8: A frame starts only while `tx_en`=1. Clearing `tx_en` during a frame lets that frame finish, after which the controller returns to IDLE even if a word is waiting.
- R9: In push-pull mode (`open_drain`=0), `txd_oe` is 1 while `tx_en`=1 or a frame is on the line, and 0 otherwise. `txd_o` is the current bit during a frame and 1 otherwise.
- R10: In open-drain mode (`open_drain`=1), `txd_o` is 0 and `txd_oe` is 1 only during a frame whose current bit is 0. The line is therefore only ever pulled low or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clocks per tick (0 treated as 1) |
| tx_en | input | 1 | Allows new frames to start |
| nine_bit | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en | input | 1 | Replace the last data bit with parity |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| open_drain | input | 1 | 1: open-drain line drive |
| wr_strobe | input | 1 | Write the holding register |
| wr_data | input | DATA_W | Word to write |
| txd_o | output | 1 | Line output value |
| txd_oe | output | 1 | Line output enable |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |

## Verification
Write strobes and state changes register on the next clock edge, so `tdre`, `tc` and a new start bit are all visible one cycle after the stimulus that causes them. `txd_oe` also follows `tx_en` and `open_drain` within the same cycle. The bench's behavioural model advances at each rising edge and is compared 2 ns later. Inputs change only at falling edges, so the comparison always sees settled outputs. A separate measurement of the start-bit length checks the window allowed by the free-running tick.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;
endpackage

// File: rtl/dbtx_tick.sv
module dbtx_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    always_comb last = (divisor == '0) ? '0 : divisor - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/dbtx_hold.sv
module dbtx_hold #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] word,
    output logic              empty
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            empty <= 1'b1;
        end else if (wr) begin
            word  <= wdata;
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end
endmodule

// File: rtl/dbtx_shift.sv
module dbtx_shift #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              nine,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              tick,
    output logic              line,
    output logic              bit_end
);
    localparam int SR_W = DATA_W + 2;

    logic [SR_W-1:0]   sr;
    logic [3:0]        sub;
    logic [DATA_W-1:0] word;
    logic              acc;
    int                kidx;

    always_comb begin
        kidx = nine ? DATA_W - 1 : DATA_W - 2;
        acc  = par_odd;
        for (int i = 0; i < DATA_W - 1; i++) begin
            if (i < kidx) acc = acc ^ data[i];
        end
        word = data;
        if (par_en) word[kidx] = acc;
        if (!nine) word[DATA_W-1] = 1'b1;
    end

    assign bit_end = tick && (sub == 4'hF);
    assign line    = sr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '1;
            sub <= '0;
        end else if (load) begin
            sr  <= {1'b1, word, 1'b0};
            sub <= '0;
        end else if (tick) begin
            sub <= sub + 1'b1;
            if (bit_end) sr <= {1'b1, sr[SR_W-1:1]};
        end
    end
endmodule

// File: rtl/dbtx_uart.sv
module dbtx_uart #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              open_drain,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd_o,
    output logic              txd_oe,
    output logic              tdre,
    output logic              tc
);
    import dbtx_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);

    tx_state_t         state, state_nx;
    logic [CNT_W-1:0]  bcnt;
    logic              nine_l;
    logic              tick, bit_end, line, load_go, busy;
    logic [DATA_W-1:0] held;

    dbtx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    dbtx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(wr_strobe), .wdata(wr_data),
        .take(load_go), .word(held), .empty(tdre)
    );

    dbtx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_go), .data(held),
        .nine(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .tick(tick), .line(line), .bit_end(bit_end)
    );

    assign load_go = tx_en && !tdre &&
                     ((state == ST_IDLE) || (state == ST_STOP && bit_end));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (load_go) state_nx = ST_START;
            ST_START: if (bit_end) state_nx = ST_DATA;
            ST_DATA:  if (bit_end && bcnt == CNT_W'(nine_l ? DATA_W - 1 : DATA_W - 2))
                          state_nx = ST_STOP;
            ST_STOP:  if (bit_end) state_nx = load_go ? ST_START : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bcnt   <= '0;
            nine_l <= 1'b0;
            tc     <= 1'b1;
        end else begin
            state <= state_nx;
            if (load_go) begin
                nine_l <= nine_bit;
                tc     <= 1'b0;
            end else if (state == ST_STOP && bit_end && tdre) begin
                tc <= 1'b1;
            end
            if (state == ST_START) bcnt <= '0;
            else if (state == ST_DATA && bit_end) bcnt <= bcnt + 1'b1;
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        if (open_drain) begin
            txd_o  = 1'b0;
            txd_oe = busy && !line;
        end else begin
            txd_o  = busy ? line : 1'b1;
            txd_oe = tx_en || busy;
        end
    end
endmodule

// File: rtl/dbtx_checker.sv
module dbtx_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_en,
    input logic                open_drain,
    input logic                wr_strobe,
    input logic                txd_o,
    input logic                txd_oe,
    input logic                tdre,
    input logic                tc,
    input dbtx_pkg::tx_state_t state
);
    import dbtx_pkg::*;

    AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !tdre); // R6
    AST_TC_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> state == ST_IDLE); // R7
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !tx_en) |=> state == ST_IDLE); // R8
    AST_FRAME_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !tx_en) |=> state != ST_IDLE); // R8
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && !open_drain) |-> !txd_o); // R3
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !open_drain) |-> txd_o); // R9
    AST_OD_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (open_drain && state == ST_IDLE) |-> !txd_oe); // R10
endmodule

bind dbtx_uart dbtx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .open_drain(open_drain),
    .wr_strobe(wr_strobe), .txd_o(txd_o), .txd_oe(txd_oe),
    .tdre(tdre), .tc(tc), .state(state)
);

// File: tb/dbtx_uart_test.sv
module dbtx_uart_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = 16'd2;
    logic        tx_en = 1'b0, nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic        open_drain = 1'b0, wr_strobe = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        txd_o, txd_oe, tdre, tc;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference state
    int  pcnt = 0, sub = 0;
    bit  mtick = 0, mact = 0, mtdre = 1, mtc = 1;
    bit  q[$];
    logic [8:0] mhold = '0;

    dbtx_uart uut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tx_en(tx_en),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .open_drain(open_drain), .wr_strobe(wr_strobe), .wr_data(wr_data),
        .txd_o(txd_o), .txd_oe(txd_oe), .tdre(tdre), .tc(tc)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit ot, end_now;
        int last, k;
        bit p;
        if (!rst_n) begin
            pcnt = 0; sub = 0; mtick = 0; mact = 0; mtdre = 1; mtc = 1;
            q.delete(); mhold = '0;
            return;
        end
        ot = mtick; end_now = 0;
        last = (divisor == 0) ? 0 : int'(divisor) - 1;
        if (pcnt >= last) begin pcnt = 0; mtick = 1; end
        else begin pcnt++; mtick = 0; end
        if (mact && ot) begin
            if (sub == 15) begin
                sub = 0;
                void'(q.pop_front());
                if (q.size() == 0) begin mact = 0; end_now = 1; end
            end else sub++;
        end
        if (!mact && tx_en && !mtdre) begin
            k = nine_bit ? 9 : 8;
            q.delete();
            q.push_back(1'b0);
            p = par_odd;
            for (int i = 0; i < k - 1; i++) p = p ^ mhold[i];
            for (int i = 0; i < k; i++)
                q.push_back((par_en && i == k - 1) ? p : mhold[i]);
            q.push_back(1'b1);
            mact = 1; sub = 0; mtdre = 1; mtc = 0;
        end else if (end_now && mtdre) begin
            mtc = 1;
        end
        if (wr_strobe) begin mhold = wr_data; mtdre = 0; end
    endtask

    always @(posedge clk) begin
        model_step();
        #2;
        if (rst_n && !done) begin
            check("R6 tdre", tdre, mtdre);
            check("R7 tc", tc, mtc);
            if (open_drain) begin
                check("R10 txd_o", txd_o, 1'b0);
                check("R10 txd_oe", txd_oe, mact && !q[0]);
            end else begin
                check("R3 R4 R5 txd_o", txd_o, mact ? q[0] : 1'b1);
                check("R9 txd_oe", txd_oe, tx_en || mact);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(logic [8:0] d);
        @(negedge clk);
        wr_strobe = 1'b1; wr_data = d;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic wait_quiet();
        int n = 0;
        while ((mact || !mtdre) && n < 20000) begin @(negedge clk); n++; end
        cyc(3);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lowcnt;
        cyc(3);
        // R1 reset values
        check("R1 tdre", tdre, 1'b1);
        check("R1 tc", tc, 1'b1);
        check("R1 txd_o", txd_o, 1'b1);
        @(negedge clk) rst_n = 1'b1;
        cyc(2);
        check("R1 tc after release", tc, 1'b1);

        // R8: no frame while disabled
        write_word(9'h0A5);
        cyc(100);
        check("R8 held while disabled", tdre, 1'b0);
        check("R8 line idle", txd_o, 1'b1);
        tx_en = 1'b1;
        wait_quiet();
        check("R7 tc after frame", tc, 1'b1);

        // R5 back to back, 9-bit
        nine_bit = 1'b1;
        write_word(9'h13C);
        cyc(10);
        write_word(9'h0C3);
        wait_quiet();

        // R4 parity even and odd, both widths
        par_en = 1'b1;
        write_word(9'h1F7); wait_quiet();
        par_odd = 1'b1;
        write_word(9'h055); wait_quiet();
        nine_bit = 1'b0;
        write_word(9'h0B3); wait_quiet();
        par_odd = 1'b0;
        write_word(9'h06E); wait_quiet();
        par_en = 1'b0;

        // R6 overwrite while busy, R8 disable mid-frame
        write_word(9'h011);
        cyc(20);
        write_word(9'h022);
        write_word(9'h0F0);
        cyc(40);
        tx_en = 1'b0;
        cyc(800);
        check("R8 waiting word kept", tdre, 1'b0);
        check("R8 frame finished", txd_o, 1'b1);
        tx_en = 1'b1;
        wait_quiet();

        // R10 open-drain
        open_drain = 1'b1;
        write_word(9'h05A);
        write_word(9'h1FF);
        wait_quiet();
        open_drain = 1'b0;

        // R2 divisor 1 and 0
        divisor = 16'd1;
        write_word(9'h0E1); wait_quiet();
        divisor = 16'd0;
        write_word(9'h01E); wait_quiet();

        // R2 start bit width with divisor 3
        divisor = 16'd3;
        write_word(9'h0FF);
        while (txd_o) @(negedge clk);
        lowcnt = 0;
        while (!txd_o && lowcnt < 1000) begin @(negedge clk); lowcnt++; end
        checks++;
        if (lowcnt < 46 || lowcnt > 48) begin
            errors++;
            $display("FAIL R2 start width actual=%0d expected=46..48", lowcnt);
        end
        wait_quiet();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule